// File: doc/BRIEF.md
# Batch-Filled Receive FIFO for an I2C Master

This block is the receive buffer that sits between a byte-level I2C master engine and the host register interface. When a receive batch is started, the buffer asks the engine for one byte at a time until it holds a programmed threshold number of bytes or runs out of room. It then raises a threshold-reached flag. If the host has armed a sticky last-byte request, it emits a one-cycle nack request so that the engine refuses the final byte of the transfer.

The host drains the buffer by reading the data register. Each read returns the oldest byte and advances a circular read pointer. The host starts the next batch in one of two ways: it acknowledges the threshold flag, or it reads the data register while the buffer is empty. A clear command empties the buffer. A pending stop is carried out when the host reads the last remaining byte, or reads with nothing left. The block also reports whether data is ready, a full-buffer event flag, and whether it is empty, full or busy filling.

Top module: `i2c_rx_batch_fifo`

## Requirements
- R1: After reset, the receive-control register (select 1) reads 0x01: threshold field bits 4:0 = 1, last-byte bit 5 = 0, threshold interrupt enable bit 6 = 0. The receive-status register (select 2) reads 0x00. The FIFO control-status register (select 3) reads 0x00. `data_ready` and `fill_busy` are 0 and `fifo_empty` is 1.
- R2: A started fill raises `byte_req` and stores each byte accepted while `byte_req` and `byte_vld` are both high. It stops once the count is at least the threshold or reaches the depth of 16. A start while the count equals the threshold does nothing.
- R3: At the end of a fill whose count is at least the threshold, bit 6 of the receive-status register is set. Bits 4:0 of that register hold the count. A threshold above 16 ends the fill at 16 bytes with bit 6 clear.
- R4: Writing 1 to receive-control bit 5 sets the last-byte flag; writing 0 there leaves it unchanged. When a fill reaches the threshold with the flag set, `nack_last` pulses for one cycle and the flag clears.
- R5: A data-register read (select 0) with a non-zero count returns the oldest byte, removes it and decrements the count. The read pointer wraps after entry 15, so bytes come out in arrival order across the wrap.
- R6: A data read with a count of 0, `rx_active` high and `stop_pending` low starts a fill. It returns the byte popped most recently.
- R7: Writing 1 to receive-status bit 6 clears the threshold flag. If `rx_active` is high, the same write starts a fill.
- R8: When a fill reaches the threshold with a full buffer, `data_ready` is set and the buffer-event flag (FIFO control-status bit 1) is set. When it reaches the threshold without filling the buffer, `data_ready` becomes the inverse of the interrupt enable. A fill that stops short of the threshold leaves both unchanged.
- R9: Writing 1 to FIFO control-status bit 6 sets the count to 0 and clears the threshold flag and the buffer-event flag. Writing 1 to bit 1 clears only the buffer-event flag.
- R10: With `stop_pending` high, a data read at a count of 0 or 1 pulses `stop_exec` for one cycle. At count 1 it still pops the byte. At count 0 it neither pops nor starts a fill.
- R11: While `fill_busy` is high, data reads, threshold acknowledges and clear commands have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 2 | Register select: 0 data, 1 receive control, 2 receive status, 3 FIFO control-status |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle (a data read pops) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the selected register (combinational) |
| rx_active | input | 1 | Controller is in a receive transfer |
| stop_pending | input | 1 | Controller has a stop waiting for the final read |
| fill_start | input | 1 | Controller request to start a fill (address phase done) |
| byte_req | output | 1 | Request for one more byte from the engine |
| byte_vld | input | 1 | Engine presents a received byte |
| byte_data | input | 8 | Received byte |
| nack_last | output | 1 | One-cycle request to nack the final byte |
| stop_exec | output | 1 | One-cycle request to carry out the pending stop |
| data_ready | output | 1 | Data-ready status |
| fill_busy | output | 1 | A fill is in progress |
| fifo_count | output | 5 | Bytes held |
| fifo_empty | output | 1 | Count is 0 |
| fifo_full | output | 1 | Count is 16 |

## Verification
The assertions assume that the engine only presents bytes in response to `byte_req`. They also assume that host strobes last one cycle and that data reads, acknowledges and clears are not issued in the same cycle as a fill completion. The bench keeps to these assumptions: it drives the engine model from `byte_req` with random stalls, and it waits for `fill_busy` to drop before most host accesses. The exception is a deliberate set of accesses during a stalled fill, which checks that they are ignored. Thresholds and read counts are drawn at random, including thresholds above the depth and thresholds equal to or below the current count.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        SEL_DATA   = 2'd0,
        SEL_RXCTL  = 2'd1,
        SEL_RXSTAT = 2'd2,
        SEL_FIFOCS = 2'd3
    } reg_sel_e;

    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_RUN  = 1'b1
    } fill_state_e;

    localparam int unsigned CTL_LAST_BIT = 5;
    localparam int unsigned CTL_IE_BIT   = 6;
    localparam int unsigned STS_HIT_BIT  = 6;
    localparam int unsigned CS_EVT_BIT   = 1;
    localparam int unsigned CS_CLR_BIT   = 6;

    typedef struct packed {
        logic data_rd;
        logic ctl_wr;
        logic hit_ack;
        logic clr;
        logic evt_w1c;
    } host_cmd_t;

    function automatic host_cmd_t decode_host(input logic [1:0] sel, input logic wr,
                                              input logic rd, input logic [7:0] wd,
                                              input logic busy);
        host_cmd_t c;
        c.data_rd = rd && (sel == SEL_DATA) && !busy;
        c.ctl_wr  = wr && (sel == SEL_RXCTL);
        c.hit_ack = wr && (sel == SEL_RXSTAT) && wd[STS_HIT_BIT] && !busy;
        c.clr     = wr && (sel == SEL_FIFOCS) && wd[CS_CLR_BIT] && !busy;
        c.evt_w1c = wr && (sel == SEL_FIFOCS) && wd[CS_EVT_BIT];
        return c;
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              clear,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  cnt_q;
    logic [PTR_W-1:0]  wr_idx;
    logic              push_ok;
    logic              pop_ok;

    assign wr_idx  = rd_ptr + cnt_q[PTR_W-1:0];
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_idx] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (pop_ok) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            if (clear) begin
                cnt_q <= '0;
            end else begin
                case ({push_ok, pop_ok})
                    2'b10:   cnt_q <= cnt_q + 1'b1;
                    2'b01:   cnt_q <= cnt_q - 1'b1;
                    default: cnt_q <= cnt_q;
                endcase
            end
        end
    end

    // R2: the fill controller never offers a byte to a full store
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R5: pops are only issued when something is held
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    // R5: count moves by at most one per cycle unless cleared
    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (cnt_q <= $past(cnt_q) + 1'b1) && (cnt_q + 1'b1 >= $past(cnt_q)));

endmodule

// File: rtl/rxf_fill_fsm.sv
module rxf_fill_fsm
    import rxf_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] thr,
    input  logic             full,
    output logic             byte_req,
    output logic             busy,
    output logic             finish
);
    fill_state_e state_q;
    logic        enough;

    assign enough   = (count >= thr) || full;
    assign busy     = (state_q == FILL_RUN);
    assign byte_req = busy && !enough;
    assign finish   = busy && enough;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FILL_IDLE;
        end else begin
            case (state_q)
                FILL_IDLE: if (start && (count != thr)) state_q <= FILL_RUN;
                FILL_RUN:  if (enough) state_q <= FILL_IDLE;
                default:   state_q <= FILL_IDLE;
            endcase
        end
    end

    // R2: a start with the count already at the threshold leaves the block idle
    assert_start_at_thr_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && (count == thr)) |=> !busy);

endmodule

// File: rtl/rxf_flags.sv
module rxf_flags
    import rxf_pkg::*;
#(
    parameter int THR_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  host_cmd_t        cmd,
    input  logic [7:0]       wdata,
    input  logic             finish,
    input  logic             reached,
    input  logic             at_full,
    output logic [THR_W-1:0] thr,
    output logic             last_q,
    output logic             ie_q,
    output logic             thr_hit,
    output logic             data_ready,
    output logic             buf_event,
    output logic             nack_last
);
    logic done_ok;
    assign done_ok = finish && reached;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr        <= THR_W'(1);
            last_q     <= 1'b0;
            ie_q       <= 1'b0;
            thr_hit    <= 1'b0;
            data_ready <= 1'b0;
            buf_event  <= 1'b0;
            nack_last  <= 1'b0;
        end else begin
            nack_last <= done_ok && last_q;
            if (cmd.ctl_wr) begin
                thr  <= wdata[THR_W-1:0];
                ie_q <= wdata[CTL_IE_BIT];
                if (wdata[CTL_LAST_BIT]) last_q <= 1'b1;
            end
            if (done_ok && last_q) begin
                last_q <= 1'b0;
            end
            if (done_ok) begin
                thr_hit <= 1'b1;
            end else if (cmd.hit_ack || cmd.clr) begin
                thr_hit <= 1'b0;
            end
            if (done_ok && at_full) begin
                buf_event <= 1'b1;
            end else if (cmd.clr || cmd.evt_w1c) begin
                buf_event <= 1'b0;
            end
            if (done_ok) begin
                data_ready <= at_full ? 1'b1 : !ie_q;
            end
        end
    end

    // R4: the nack request only accompanies a reached threshold
    assert_nack_hit_R4: assert property (@(posedge clk) disable iff (rst)
        nack_last |-> thr_hit);
    // R4: the last-byte flag is consumed when the nack is issued
    assert_last_consumed_R4: assert property (@(posedge clk) disable iff (rst)
        nack_last |-> !last_q);
    // R3: the threshold flag only rises at the end of a fill
    assert_hit_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(thr_hit) |-> $past(finish));
    // R8: a buffer event always comes with data ready
    assert_evt_ready_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_event) |-> data_ready);
    // R9: a clear command drops both flags
    assert_clear_flags_R9: assert property (@(posedge clk) disable iff (rst)
        cmd.clr |=> !thr_hit && !buf_event);

endmodule

// File: rtl/i2c_rx_batch_fifo.sv
module i2c_rx_batch_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              rx_active,
    input  logic              stop_pending,
    input  logic              fill_start,
    output logic              byte_req,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    output logic              nack_last,
    output logic              stop_exec,
    output logic              data_ready,
    output logic              fill_busy,
    output logic [CNT_W-1:0]  fifo_count,
    output logic              fifo_empty,
    output logic              fifo_full
);
    host_cmd_t         cmd;
    logic [DATA_W-1:0] head;
    logic [DATA_W-1:0] last_byte;
    logic [CNT_W-1:0]  thr;
    logic              last_q, ie_q, thr_hit, buf_event;
    logic              finish, reached, push, pop, start, read_fill;

    assign cmd       = decode_host(host_sel, host_wr, host_rd, host_wdata, fill_busy);
    assign push      = byte_req && byte_vld;
    assign pop       = cmd.data_rd && !fifo_empty;
    assign reached   = (fifo_count >= thr);
    assign read_fill = cmd.data_rd && fifo_empty && rx_active && !stop_pending;
    assign start     = fill_start || read_fill || (cmd.hit_ack && rx_active);

    rxf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .push(push), .push_data(byte_data), .pop(pop),
        .clear(cmd.clr), .head(head), .count(fifo_count), .full(fifo_full),
        .empty(fifo_empty)
    );

    rxf_fill_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst(rst), .start(start), .count(fifo_count), .thr(thr),
        .full(fifo_full), .byte_req(byte_req), .busy(fill_busy), .finish(finish)
    );

    rxf_flags #(.THR_W(CNT_W)) u_flags (
        .clk(clk), .rst(rst), .cmd(cmd), .wdata(host_wdata), .finish(finish),
        .reached(reached), .at_full(fifo_full), .thr(thr), .last_q(last_q),
        .ie_q(ie_q), .thr_hit(thr_hit), .data_ready(data_ready),
        .buf_event(buf_event), .nack_last(nack_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            last_byte <= '0;
            stop_exec <= 1'b0;
        end else begin
            stop_exec <= cmd.data_rd && stop_pending && (fifo_count <= CNT_W'(1));
            if (pop) last_byte <= head;
        end
    end

    always_comb begin
        host_rdata = '0;
        case (reg_sel_e'(host_sel))
            SEL_DATA:   host_rdata = fifo_empty ? 8'(last_byte) : 8'(head);
            SEL_RXCTL:  host_rdata = {1'b0, ie_q, last_q, 5'(thr)};
            SEL_RXSTAT: host_rdata = {1'b0, thr_hit, 1'b0, 5'(fifo_count)};
            SEL_FIFOCS: host_rdata = {6'b0, buf_event, 1'b0};
            default:    host_rdata = '0;
        endcase
    end

    // R11: no pop is taken while a fill runs
    assert_busy_blocks_pop_R11: assert property (@(posedge clk) disable iff (rst)
        (fill_busy && host_rd && (host_sel == SEL_DATA)) |=> $stable(fifo_count) || fill_busy || $past(push));
    // R10: the stop request only follows a read made with a stop pending
    assert_stop_cause_R10: assert property (@(posedge clk) disable iff (rst)
        stop_exec |-> $past(stop_pending) && $past(host_rd));
    // R2: bytes are only requested while the store has room
    assert_req_room_R2: assert property (@(posedge clk) disable iff (rst)
        byte_req |-> !fifo_full && fill_busy);

endmodule

// File: tb/tb_i2c_rx_batch_fifo.sv
module tb_i2c_rx_batch_fifo;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] host_sel = 2'd0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       rx_active = 1'b1, stop_pending = 1'b0, fill_start = 1'b0;
    logic       byte_req, byte_vld = 1'b0;
    logic [7:0] byte_data = 8'd0;
    logic       nack_last, stop_exec, data_ready, fill_busy;
    logic [4:0] fifo_count;
    logic       fifo_empty, fifo_full;

    int checks = 0, fails = 0;
    int nack_cnt = 0, stop_cnt = 0;
    bit stall = 1'b0, acc_pend = 1'b0, finished = 1'b0;
    logic [7:0] mq[$];

    always #4 clk = ~clk;

    i2c_rx_batch_fifo dut (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .rx_active(rx_active),
        .stop_pending(stop_pending), .fill_start(fill_start), .byte_req(byte_req),
        .byte_vld(byte_vld), .byte_data(byte_data), .nack_last(nack_last),
        .stop_exec(stop_exec), .data_ready(data_ready), .fill_busy(fill_busy),
        .fifo_count(fifo_count), .fifo_empty(fifo_empty), .fifo_full(fifo_full)
    );

    // byte engine model and pulse monitors
    always @(negedge clk) begin
        if (acc_pend) begin
            mq.push_back(byte_data);
            byte_data = 8'($urandom);
        end
        byte_vld = !stall && ($urandom_range(3) != 0);
        acc_pend = byte_req && byte_vld && !rst;
        if (nack_last) nack_cnt++;
        if (stop_exec) stop_cnt++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk); host_sel = sel; host_wr = 1'b1; host_wdata = d;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] sel, output logic [7:0] d);
        @(negedge clk); host_sel = sel; host_rd = 1'b1; #1 d = host_rdata;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); fill_start = 1'b1;
        @(negedge clk); fill_start = 1'b0;
    endtask

    task automatic wait_fill();
        for (int i = 0; i < 400 && fill_busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    // pop one byte and compare against the engine model's order
    task automatic pop_check(input string req);
        logic [7:0] d, e;
        e = mq.pop_front();
        host_read(2'd0, d);
        check(req, d, e);
    endtask

    function automatic int exp_fill(input int c, input int t);
        if (c >= t) return c;
        return (t > 16) ? 16 : t;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, v;
        int c, t, ie, f, k, exp_dr;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        host_read(2'd1, d); check("R1 rxctl", d, 8'h01);
        host_read(2'd2, d); check("R1 rxstat", d, 8'h00);
        host_read(2'd3, d); check("R1 fifocs", d, 8'h00);
        check("R1 data_ready", data_ready, 0);
        check("R1 busy", fill_busy, 0);
        check("R1 empty", fifo_empty, 1);

        // R2 R3 R8 basic fill
        host_write(2'd1, 8'h04);
        pulse_start(); wait_fill();
        check("R2 count", fifo_count, 4);
        host_read(2'd2, d); check("R3 rxstat", d, 8'h44);
        check("R8 data_ready ie0", data_ready, 1);
        check("R4 no nack", nack_cnt, 0);
        pulse_start();
        check("R2 no fill at thr", fill_busy, 0);
        check("R2 count kept", fifo_count, 4);

        // R5 ordered pops
        for (int i = 0; i < 4; i++) pop_check("R5 data");
        check("R5 count zero", fifo_count, 0);

        // R7 ack starts fill; R8 ie set clears data_ready
        host_write(2'd1, 8'h45);
        host_write(2'd2, 8'h40); wait_fill();
        check("R7 count", fifo_count, 5);
        host_read(2'd2, d); check("R7 rxstat", d, 8'h45);
        check("R8 data_ready ie1", data_ready, 0);

        // R4 sticky last-byte flag
        host_write(2'd1, 8'h25);
        host_read(2'd1, d); check("R4 last set", d, 8'h25);
        host_write(2'd1, 8'h05);
        host_read(2'd1, d); check("R4 write0 keeps", d, 8'h25);
        pop_check("R5 data"); pop_check("R5 data");
        host_write(2'd2, 8'h40); wait_fill();
        check("R4 nack pulse", nack_cnt, 1);
        host_read(2'd1, d); check("R4 last cleared", d, 8'h05);
        check("R8 data_ready", data_ready, 1);

        // R6 read at empty starts fill, returns last popped
        for (int i = 0; i < 4; i++) pop_check("R5 data");
        v = mq[0];
        pop_check("R5 data");
        host_read(2'd0, d); check("R6 hold data", d, v);
        wait_fill();
        check("R6 fill count", fifo_count, 5);

        // R9 clear
        host_write(2'd3, 8'h40); mq.delete();
        check("R9 count", fifo_count, 0);
        host_read(2'd2, d); check("R9 rxstat", d, 8'h00);

        // R3 threshold above depth
        host_write(2'd1, 8'h14);
        pulse_start(); wait_fill();
        check("R3 full", fifo_full, 1);
        host_read(2'd2, d); check("R3 no hit", d, 8'h10);
        host_read(2'd3, d); check("R8 no evt", d, 8'h00);

        // R5 wrap and R8 full event
        for (int i = 0; i < 6; i++) pop_check("R5 data");
        host_write(2'd1, 8'h10);
        pulse_start(); wait_fill();
        host_read(2'd2, d); check("R3 hit full", d, 8'h50);
        host_read(2'd3, d); check("R8 evt", d, 8'h02);
        check("R8 data_ready full", data_ready, 1);
        for (int i = 0; i < 16; i++) pop_check("R5 wrap data");
        host_write(2'd3, 8'h02);
        host_read(2'd3, d); check("R9 evt w1c", d, 8'h00);

        // R11 accesses during a stalled fill
        host_write(2'd1, 8'h08); pulse_start(); wait_fill();
        host_write(2'd1, 8'h0C);
        stall = 1'b1;
        host_write(2'd2, 8'h40);
        check("R11 busy", fill_busy, 1);
        host_read(2'd0, d);
        check("R11 read ignored", fifo_count, 8);
        host_write(2'd3, 8'h40);
        check("R11 clear ignored", fifo_count, 8);
        stall = 1'b0; wait_fill();
        check("R11 resumed", fifo_count, 12);

        // R10 stop on final reads
        stop_pending = 1'b1;
        for (int i = 0; i < 11; i++) pop_check("R10 data");
        @(negedge clk); check("R10 no early stop", stop_cnt, 0);
        pop_check("R10 last data");
        @(negedge clk); check("R10 stop at one", stop_cnt, 1);
        check("R10 count", fifo_count, 0);
        host_read(2'd0, d);
        @(negedge clk); check("R10 stop at zero", stop_cnt, 2);
        check("R10 no fill", fill_busy, 0);
        check("R10 still empty", fifo_count, 0);
        stop_pending = 1'b0;

        // random batches
        exp_dr = 1;
        for (int it = 0; it < 40; it++) begin
            c = fifo_count;
            t = $urandom_range(20);
            ie = $urandom_range(1);
            rx_active = 1'b0; host_write(2'd2, 8'h40); rx_active = 1'b1;
            host_write(2'd1, 8'(t) | (ie ? 8'h40 : 8'h00));
            pulse_start(); wait_fill();
            f = exp_fill(c, t);
            check("R2 rand count", fifo_count, f);
            host_read(2'd2, d);
            check("R3 rand hit", d[6], (c != t) && (f >= t));
            if ((c != t) && (f >= t)) exp_dr = (f == 16) ? 1 : !ie;
            check("R8 rand ready", data_ready, exp_dr);
            k = $urandom_range(f);
            for (int j = 0; j < k; j++) pop_check("R5 rand data");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule